// File: doc/BRIEF.md
# Square-Wave Output and Oscillator Status Control

This block owns the control byte of a timekeeping core. It produces one output pin that either carries a square wave or holds a static level chosen by software. It also keeps a sticky flag that records that the timekeeping oscillator has stopped.

The square wave comes from a shared binary prescaler. The prescaler advances on a strobe at twice the 32.768 kHz base rate, so each half-period of the crystal counts as one step. Four taps of that counter give 1 Hz, 4.096 kHz, 8.192 kHz and 32.768 kHz, each with a 50% duty cycle.

A write to the seconds count clears the prescaler, so the 1 Hz wave starts in phase with the new second. When the oscillator is not running, the prescaler and therefore the wave freeze. A change of rate is held back until both the old tap and the new tap are low, so the pin never shows a runt high pulse.

Top module: `wave_status_ctrl`

## Requirements
- R1: After reset the control byte reads 8'hB3: level bit 1, stop flag 1, wave enable 1, rate 2'b11. The prescaler is zero, so the wave output is 0.
- R2: The control byte has this layout: bit 7 is the static level, bit 5 is the stop flag, bit 4 is the wave enable, and bits 1:0 are the requested rate. Bits 6, 3 and 2 always read 0, even after a write of 1.
- R3: With the wave enabled and the prescaler advancing once per cycle, the output toggles every 1, 4, 8 or 32768 advances for rate 11, 10, 01 or 00 respectively. This is a level of counter bit 0, 2, 3 or 15.
- R4: With the wave enable at 0, the output equals the level bit from the cycle after the write onwards.
- R5: The stop flag becomes 1 one cycle after the oscillator-running input falls from 1 to 0.
- R6: A write with bit 5 = 0 clears the stop flag, and a write with bit 5 = 1 leaves it unchanged. If a stop event coincides with a clearing write, the flag ends at 1.
- R7: A seconds-write strobe zeroes the prescaler. With rate 00 and one advance per cycle, the output is low 32767 advances later and goes high at advance 32768, which is 500 ms of real time.
- R8: While the oscillator-running input is 0, the prescaler holds its value and the wave output holds its level.
- R9: A new rate takes effect only at a cycle in which both the active tap and the requested tap are 0. Until then the output follows the previous rate, and the output is low at the moment of the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| half_tick | input | 1 | Strobe at twice the 32.768 kHz base rate |
| osc_run | input | 1 | Oscillator is running |
| sec_wr | input | 1 | Seconds count was written; re-phase the prescaler |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| wave_out | output | 1 | Square wave or static level |

## Verification
The wave is checked cycle by cycle at each of the three fast rates, starting from a known prescaler value. Each step is compared against a tap model that the bench computes by division, so a wrong tap or a wrong rate decode shows up within a few advances. The 1 Hz rate is probed only on the two advances around the 500 ms point after a seconds write, which separates a correct re-phase from an off-by-one count or a missed clear. Rate changes are started while the old tap is high, which separates deferred switching from immediate switching. Halting the oscillator and colliding a clearing write with a stop event separate freezing from free-running and show which of set and clear has priority on the flag.

// File: rtl/wave_ctrl_pkg.sv
package wave_ctrl_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_MID  = 2'b01,
    RATE_HI   = 2'b10,
    RATE_TOP  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  lvl;
    logic  wave_en;
    rate_e rate;
  } ctrl_s;

  localparam int unsigned BIT_LVL  = 7;
  localparam int unsigned BIT_STOP = 5;
  localparam int unsigned BIT_EN   = 4;

  localparam ctrl_s CTRL_RST = '{lvl: 1'b1, wave_en: 1'b1, rate: RATE_TOP};

  function automatic logic [7:0] pack_ctrl(input ctrl_s c, input logic stop);
    logic [7:0] d;
    d = 8'h00;
    d[BIT_LVL]  = c.lvl;
    d[BIT_STOP] = stop;
    d[BIT_EN]   = c.wave_en;
    d[1:0]      = c.rate;
    return d;
  endfunction

  function automatic ctrl_s unpack_ctrl(input logic [7:0] d);
    ctrl_s c;
    c.lvl     = d[BIT_LVL];
    c.wave_en = d[BIT_EN];
    c.rate    = rate_e'(d[1:0]);
    return c;
  endfunction

  function automatic logic clears_stop(input logic wr, input logic [7:0] d);
    return wr && !d[BIT_STOP];
  endfunction

endpackage

// File: rtl/wave_prescaler.sv
module wave_prescaler #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wave_rate_sel.sv
module wave_rate_sel
  import wave_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TAP_SLOW = 15,
  parameter int unsigned TAP_MID  = 3,
  parameter int unsigned TAP_HI   = 2,
  parameter int unsigned TAP_TOP  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  rate_e            req_rate,
  output rate_e            act_rate,
  output logic             tap_lvl,
  output logic             swap
);

  logic [3:0] taps;
  rate_e      act_q;

  for (genvar i = 0; i < 4; i++) begin : g_tap
    localparam int unsigned IDX = (i == 0) ? TAP_SLOW :
                                  (i == 1) ? TAP_MID  :
                                  (i == 2) ? TAP_HI   : TAP_TOP;
    assign taps[i] = cnt[IDX];
  end

  assign swap = (act_q != req_rate) && !taps[act_q] && !taps[req_rate];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RATE_TOP;
    end else if (swap) begin
      act_q <= req_rate;
    end
  end

  assign act_rate = act_q;
  assign tap_lvl  = taps[act_q];

endmodule

// File: rtl/wave_stop_flag.sv
module wave_stop_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr_req,
  output logic flag,
  output logic stop_evt
);

  logic run_prev_q;
  logic flag_q;

  assign stop_evt = run_prev_q && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_prev_q <= 1'b0;
      flag_q     <= 1'b1;
    end else begin
      run_prev_q <= run;
      if (stop_evt) begin
        flag_q <= 1'b1;
      end else if (clr_req) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/wave_status_ctrl.sv
module wave_status_ctrl
  import wave_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TAP_SLOW = CNT_W - 1,
  parameter int unsigned TAP_MID  = 3,
  parameter int unsigned TAP_HI   = 2,
  parameter int unsigned TAP_TOP  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       osc_run,
  input  logic       sec_wr,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic       wave_out
);

  ctrl_s            ctrl_q;
  logic [CNT_W-1:0] cnt;
  logic             pre_adv;
  logic             stop_flag;
  logic             stop_evt;
  logic             stop_clr;
  logic             rate_swap;
  logic             tap_lvl;
  rate_e            act_rate;
  logic             unused_bits;

  assign unused_bits = ^{ctl_wdata[6], ctl_wdata[3:2], act_rate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ctl_wr) begin
      ctrl_q <= unpack_ctrl(ctl_wdata);
    end
  end

  assign pre_adv  = half_tick && osc_run;
  assign stop_clr = clears_stop(ctl_wr, ctl_wdata);

  wave_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pre_adv),
    .clr   (sec_wr),
    .cnt   (cnt)
  );

  wave_rate_sel #(
    .CNT_W    (CNT_W),
    .TAP_SLOW (TAP_SLOW),
    .TAP_MID  (TAP_MID),
    .TAP_HI   (TAP_HI),
    .TAP_TOP  (TAP_TOP)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .req_rate (ctrl_q.rate),
    .act_rate (act_rate),
    .tap_lvl  (tap_lvl),
    .swap     (rate_swap)
  );

  wave_stop_flag u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (osc_run),
    .clr_req  (stop_clr),
    .flag     (stop_flag),
    .stop_evt (stop_evt)
  );

  assign ctl_rdata = pack_ctrl(ctrl_q, stop_flag);
  assign wave_out  = ctrl_q.wave_en ? tap_lvl : ctrl_q.lvl;

endmodule

// File: rtl/wave_status_ctrl_chk.sv
module wave_status_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             half_tick,
  input logic             osc_run,
  input logic             sec_wr,
  input logic             ctl_wr,
  input logic [7:0]       ctl_wdata,
  input logic [7:0]       ctl_rdata,
  input logic             wave_out,
  input logic [CNT_W-1:0] cnt,
  input logic             stop_evt,
  input logic             rate_swap
);

  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6] == 1'b0) && (ctl_rdata[3:2] == 2'b00));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_run && half_tick && !sec_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[4] |-> (wave_out == ctl_rdata[7]));

  // R5
  stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> ctl_rdata[5]);

  // R6
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[5] && !(ctl_wr && !ctl_wdata[5])) |=> ctl_rdata[5]);

  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[5] && !stop_evt) |=> !ctl_rdata[5]);

  // R7
  sec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> (cnt == '0));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && !sec_wr) |=> $stable(cnt));

  // R8
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && !sec_wr && !ctl_wr && !rate_swap) |=> $stable(wave_out));

  // R9
  swap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_swap && ctl_rdata[4]) |-> !wave_out);

endmodule

bind wave_status_ctrl wave_status_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .half_tick (half_tick),
  .osc_run   (osc_run),
  .sec_wr    (sec_wr),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .wave_out  (wave_out),
  .cnt       (cnt),
  .stop_evt  (stop_evt),
  .rate_swap (rate_swap)
);

// File: tb/tb_wave_status_ctrl.sv
module tb_wave_status_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d_tick = 1'b0;
  logic       d_run = 1'b0;
  logic       d_sec = 1'b0;
  logic       d_wr = 1'b0;
  logic [7:0] d_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       wave_out;

  always #2 clk = ~clk;

  wave_status_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (d_tick),
    .osc_run   (d_run),
    .sec_wr    (d_sec),
    .ctl_wr    (d_wr),
    .ctl_wdata (d_wdata),
    .ctl_rdata (ctl_rdata),
    .wave_out  (wave_out)
  );

  typedef struct {
    string      tag;
    bit         is_reg;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;

  // reference model, built from the requirements
  int unsigned m_cnt = 0;
  logic [1:0]  m_req = 2'b11;
  logic [1:0]  m_act = 2'b11;
  logic        m_lvl = 1'b1;
  logic        m_en = 1'b1;
  logic        m_osf = 1'b1;
  logic        m_prev = 1'b0;

  function automatic logic tap(input logic [1:0] r, input int unsigned c);
    int unsigned half;
    half = (r == 2'b00) ? 32768 : (r == 2'b01) ? 8 : (r == 2'b10) ? 4 : 1;
    return ((c / half) % 2) == 1;
  endfunction

  function automatic logic [7:0] m_reg();
    return {m_lvl, 1'b0, m_osf, m_en, 2'b00, m_req};
  endfunction

  function automatic logic m_wave();
    return m_en ? tap(m_act, m_cnt) : m_lvl;
  endfunction

  task automatic edge_step();
    @(posedge clk);
    if (m_act != m_req && !tap(m_act, m_cnt) && !tap(m_req, m_cnt)) m_act = m_req;
    if (m_prev && !d_run) m_osf = 1'b1;
    else if (d_wr && !d_wdata[5]) m_osf = 1'b0;
    m_prev = d_run;
    if (d_sec) m_cnt = 0;
    else if (d_tick && d_run) m_cnt = (m_cnt + 1) % 65536;
    if (d_wr) begin
      m_lvl = d_wdata[7];
      m_en  = d_wdata[4];
      m_req = d_wdata[1:0];
    end
    #1;
  endtask

  task automatic expect_wave(input string tag);
    item_t it;
    it.tag = tag; it.is_reg = 1'b0; it.exp = {7'b0, m_wave()};
    q.push_back(it);
  endtask

  task automatic expect_reg(input string tag);
    item_t it;
    it.tag = tag; it.is_reg = 1'b1; it.exp = m_reg();
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] data);
    d_wr = 1'b1; d_wdata = data;
    edge_step();
    d_wr = 1'b0;
  endtask

  task automatic run_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      edge_step();
      expect_wave(tag);
    end
  endtask

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_reg ? ctl_rdata : {7'b0, wave_out};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic finish_run();
    @(negedge clk);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edge_step();
    // R1 reset state
    expect_reg("R1");
    expect_wave("R1");
    d_run = 1'b1;
    edge_step();
    // R2 reserved bits stay 0; R6 writing 1 to the flag keeps it
    wr(8'hFF);
    expect_reg("R2");
    wr(8'h93);
    expect_reg("R6");
    // R3 fastest rate, one advance per cycle
    d_tick = 1'b1;
    run_check(12, "R3");
    wr(8'h92);
    run_check(40, "R3");
    wr(8'h91);
    run_check(40, "R3");
    // R9 request a new rate while the old tap is high
    while (!tap(m_act, m_cnt)) begin
      edge_step();
      expect_wave("R9");
    end
    wr(8'h93);
    expect_wave("R9");
    run_check(24, "R9");
    // R5 stop event sets the flag; R8 freeze while stopped
    d_run = 1'b0;
    edge_step();
    expect_reg("R5");
    run_check(10, "R8");
    d_run = 1'b1;
    edge_step();
    wr(8'h93);
    expect_reg("R6");
    // R6 stop event wins over a clearing write in the same cycle
    d_run = 1'b0;
    wr(8'h93);
    expect_reg("R6");
    d_run = 1'b1;
    edge_step();
    // R4 static level
    wr(8'h80);
    expect_wave("R4");
    expect_reg("R4");
    run_check(5, "R4");
    wr(8'h00);
    expect_wave("R4");
    run_check(5, "R4");
    // R7 seconds write re-phases the 1 Hz wave
    wr(8'h10);
    d_sec = 1'b1;
    edge_step();
    d_sec = 1'b0;
    expect_wave("R7");
    repeat (32767) edge_step();
    expect_wave("R7");
    edge_step();
    expect_wave("R7");
    finish_run();
  end

endmodule